// File: doc/BRIEF.md
# Event-Paced DMA Request Gate

This block sits on one DMA channel, between the peripheral's transfer request and the channel arbiter. With trigger pacing switched off it is transparent: the arbiter sees the peripheral request unchanged. With trigger pacing switched on, each pulse on the event input grants one credit, and one credit lets exactly one data item through. A request that arrives without a credit is held back. An event that arrives while no request is pending is kept, so the item starts as soon as the request appears.

The control is a three-state machine. In IDLE no credit is held and the gated request is forced low. In ARMED a credit is held and the request has not yet been presented. In ACTIVE the request has been presented and the item is in flight until the transfer-complete strobe. The transitions are: IDLE to ARMED on an event. ARMED to ACTIVE when the peripheral request is high. ACTIVE to IDLE on transfer complete. ACTIVE to ARMED on transfer complete together with a new event. Any state goes to IDLE when pacing is switched off. An event that cannot be stored, because a credit is already held, raises the overflow output toward the event system for one cycle.

Top module: `evt_dma_gate`

## Requirements
- R1: With `trig_en` low, `req_gated` equals `periph_req` in the same cycle, and events produce no `evt_overflow` pulse.
- R2: With `trig_en` high and no credit held (IDLE), `req_gated` stays low whatever `periph_req` does.
- R3: After an event is accepted in IDLE, a credit is held from the next cycle on. From then `req_gated` follows `periph_req` in the same cycle, including a request that only rises several cycles after the event.
- R4: A credit covers exactly one item. Once `xfer_done` is seen in ACTIVE with no event in the same cycle, `req_gated` is low from the next cycle until another event is accepted.
- R5: An event seen while a credit is held (ARMED, or ACTIVE without `xfer_done`) is surplus. Each such event gives a `evt_overflow` pulse of exactly one cycle, in the cycle after the event.
- R6: An event in the same cycle as `xfer_done` in ACTIVE becomes the next credit (ARMED). It gives no overflow.
- R7: `xfer_done` is ignored outside ACTIVE: a held ARMED credit is kept.
- R8: Reset puts the block in IDLE with `evt_overflow` low. Dropping `trig_en` discards any held credit, so after pacing is re-enabled, requests are blocked until a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_en | input | 1 | Event-pacing mode enable |
| periph_req | input | 1 | Transfer request from the peripheral |
| evt_pulse | input | 1 | Event pulse; each high cycle counts as one event |
| xfer_done | input | 1 | Strobe marking completion of the current item |
| req_gated | output | 1 | Request presented to the arbiter |
| evt_overflow | output | 1 | One-cycle pulse per surplus event |

## Verification
The assertions assume that all inputs are synchronous to `clk` and settled before the rising edge. They also assume that every cycle in which `evt_pulse` is high counts as a separate event, so back-to-back high cycles count as two events. The stimulus drives inputs only at the falling edge and draws them from a seeded `$urandom` stream, which keeps it within these limits. The random stream is weighted so that events, done strobes and mode changes hit every state, including the case where an event and `xfer_done` land in the same cycle. Directed sequences cover the corner cases: a late request after an ARMED credit, a stray done strobe, and a mode switch while a credit is held.

// File: rtl/evg_pkg.sv
package evg_pkg;

    typedef enum logic [1:0] {
        GATE_IDLE   = 2'd0,
        GATE_ARMED  = 2'd1,
        GATE_ACTIVE = 2'd2
    } gate_state_e;

endpackage

// File: rtl/evg_state_seq.sv
module evg_state_seq
    import evg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig_en,
    input  logic        periph_req,
    input  logic        evt_pulse,
    input  logic        xfer_done,
    output gate_state_e state_q
);

    gate_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_IDLE:   if (evt_pulse)  state_d = GATE_ARMED;
            GATE_ARMED:  if (periph_req) state_d = GATE_ACTIVE;
            GATE_ACTIVE: if (xfer_done)  state_d = evt_pulse ? GATE_ARMED : GATE_IDLE;
            default:                     state_d = GATE_IDLE;
        endcase
        if (!trig_en) state_d = GATE_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/evg_req_mux.sv
module evg_req_mux
    import evg_pkg::*;
(
    input  logic        trig_en,
    input  logic        periph_req,
    input  gate_state_e state_q,
    output logic        req_gated
);

    // output process
    always_comb begin
        req_gated = 1'b0;
        if (!trig_en) begin
            req_gated = periph_req;
        end else begin
            unique case (state_q)
                GATE_IDLE:   req_gated = 1'b0;
                GATE_ARMED,
                GATE_ACTIVE: req_gated = periph_req;
                default:     req_gated = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/evg_ovf_flag.sv
module evg_ovf_flag
    import evg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig_en,
    input  logic        evt_pulse,
    input  logic        xfer_done,
    input  gate_state_e state_q,
    output logic        evt_overflow
);

    logic credit_busy;
    logic surplus;

    always_comb begin
        credit_busy = 1'b0;
        unique case (state_q)
            GATE_IDLE:   credit_busy = 1'b0;
            GATE_ARMED:  credit_busy = 1'b1;
            GATE_ACTIVE: credit_busy = !xfer_done;
            default:     credit_busy = 1'b0;
        endcase
        surplus = trig_en && evt_pulse && credit_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_overflow <= 1'b0;
        else        evt_overflow <= surplus;
    end

endmodule

// File: rtl/evt_dma_gate.sv
module evt_dma_gate
    import evg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_en,
    input  logic periph_req,
    input  logic evt_pulse,
    input  logic xfer_done,
    output logic req_gated,
    output logic evt_overflow
);

    gate_state_e state_q;

    evg_state_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_en    (trig_en),
        .periph_req (periph_req),
        .evt_pulse  (evt_pulse),
        .xfer_done  (xfer_done),
        .state_q    (state_q)
    );

    evg_req_mux u_mux (
        .trig_en    (trig_en),
        .periph_req (periph_req),
        .state_q    (state_q),
        .req_gated  (req_gated)
    );

    evg_ovf_flag u_ovf (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_en      (trig_en),
        .evt_pulse    (evt_pulse),
        .xfer_done    (xfer_done),
        .state_q      (state_q),
        .evt_overflow (evt_overflow)
    );

endmodule

// File: rtl/evt_dma_gate_chk.sv
module evt_dma_gate_chk
    import evg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        trig_en,
    input logic        periph_req,
    input logic        evt_pulse,
    input logic        xfer_done,
    input logic        req_gated,
    input logic        evt_overflow,
    input gate_state_e state_q
);

    assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_en |-> (req_gated == periph_req));

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_en |=> !evt_overflow);

    assert_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && state_q == GATE_IDLE) |-> !req_gated);

    assert_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && state_q == GATE_IDLE && evt_pulse) |=> (!trig_en || state_q != GATE_IDLE));

    assert_one_item_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && state_q == GATE_ACTIVE && xfer_done && !evt_pulse) |=> (state_q == GATE_IDLE));

    assert_ovf_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_overflow |-> ($past(evt_pulse) && $past(trig_en) && $past(state_q) != GATE_IDLE));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && state_q == GATE_ACTIVE && xfer_done) |=> !evt_overflow);

    assert_keep_credit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && state_q == GATE_ARMED && !periph_req) |=> (!$past(trig_en) || !trig_en || state_q == GATE_ARMED || $past(trig_en) && state_q == GATE_ARMED));

    assert_drop_credit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_en |=> (state_q == GATE_IDLE));

endmodule

bind evt_dma_gate evt_dma_gate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_en      (trig_en),
    .periph_req   (periph_req),
    .evt_pulse    (evt_pulse),
    .xfer_done    (xfer_done),
    .req_gated    (req_gated),
    .evt_overflow (evt_overflow),
    .state_q      (state_q)
);

// File: tb/evt_dma_gate_tb_top.sv
`timescale 1ns/1ps
module evt_dma_gate_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_en = 1'b0;
    logic periph_req = 1'b0;
    logic evt_pulse = 1'b0;
    logic xfer_done = 1'b0;
    logic req_gated;
    logic evt_overflow;

    int checks = 0;
    int errors = 0;

    // reference model (from requirements)
    bit    m_credit = 1'b0;
    bit    m_issued = 1'b0;
    bit    exp_ovf  = 1'b0;
    string ovf_tag  = "R8";

    always #2 clk = ~clk;   // 250 MHz

    evt_dma_gate dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_en      (trig_en),
        .periph_req   (periph_req),
        .evt_pulse    (evt_pulse),
        .xfer_done    (xfer_done),
        .req_gated    (req_gated),
        .evt_overflow (evt_overflow)
    );

    function automatic bit exp_req(bit en, bit req, bit credit);
        return en ? (credit & req) : req;
    endfunction

    function automatic bit exp_surplus(bit en, bit evt, bit done, bit credit, bit issued);
        return en & evt & credit & !(issued & done);
    endfunction

    function automatic string auto_tag(bit en, bit credit);
        if (!en)    return "R1";
        if (!credit) return "R2";
        return "R3";
    endfunction

    task automatic check(string tag, string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // one cycle: check last overflow, drive, check gated request, advance model
    task automatic step(bit en, bit req, bit evt, bit done, string tag);
        @(negedge clk);
        check(ovf_tag, "evt_overflow", evt_overflow, exp_ovf);
        trig_en = en; periph_req = req; evt_pulse = evt; xfer_done = done;
        #1;
        check((tag == "") ? auto_tag(en, m_credit) : tag, "req_gated",
              req_gated, exp_req(en, req, m_credit));
        exp_ovf = exp_surplus(en, evt, done, m_credit, m_issued);
        if (!en)                         ovf_tag = "R1";
        else if (m_issued && done && evt) ovf_tag = "R6";
        else                             ovf_tag = "R5";
        if (!en) begin
            m_credit = 1'b0; m_issued = 1'b0;
        end else if (!m_credit) begin
            m_credit = evt;
        end else if (!m_issued) begin
            m_issued = req;
        end else if (done) begin
            m_credit = evt; m_issued = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        // R8: reset state
        @(negedge clk);
        check("R8", "evt_overflow in reset", evt_overflow, 1'b0);
        rst_n = 1'b1;
        trig_en = 1'b1; periph_req = 1'b1;
        #1;
        check("R8", "req_gated after reset", req_gated, 1'b0);
        periph_req = 1'b0;

        // R1: pass-through, events ignored
        step(0, 1, 1, 0, "R1");
        step(0, 0, 1, 0, "R1");
        step(0, 1, 0, 1, "R1");
        // R2: blocked without credit
        step(1, 1, 0, 0, "R2");
        step(1, 1, 0, 0, "R2");
        // R3: event with no request, late request
        step(1, 0, 1, 0, "R2");
        step(1, 0, 0, 0, "R3");
        // R7: stray done in ARMED ignored
        step(1, 0, 0, 1, "R7");
        step(1, 0, 0, 0, "R7");
        step(1, 1, 0, 0, "R3");
        // R5: surplus event in ACTIVE
        step(1, 1, 1, 0, "R5");
        step(1, 1, 0, 0, "R5");
        // R4: done ends the item
        step(1, 1, 0, 1, "R4");
        step(1, 1, 0, 0, "R4");
        step(1, 1, 0, 0, "R4");
        // R6: event together with done
        step(1, 1, 1, 0, "R3");
        step(1, 1, 0, 0, "R3");
        step(1, 1, 1, 1, "R6");
        step(1, 1, 0, 0, "R6");
        step(1, 1, 0, 1, "R4");
        // R8: drop mode while ARMED
        step(1, 0, 1, 0, "R2");
        step(1, 0, 1, 0, "R5");
        step(0, 0, 0, 0, "R8");
        step(1, 1, 0, 0, "R8");
        step(1, 1, 0, 0, "R8");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            bit en, rq, ev, dn;
            en = ($urandom % 16) != 0;
            rq = ($urandom % 3) != 0;
            ev = ($urandom % 4) == 0;
            dn = ($urandom % 3) == 0;
            step(en, rq, ev, dn, "");
        end
        step(1, 0, 0, 0, "");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule